// File: doc/BRIEF.md
# Segment Descriptor Cache

This block keeps, for each of four segment registers, a visible 16-bit selector together with three hidden companions: a 32-bit base, a 32-bit limit and a 12-bit access-rights field. Linear addresses are always formed from the hidden base plus an offset. The visible selector is never used for address formation. When it changes, it only marks the point where the hidden fields are refreshed.

A program-driven selector load refreshes the hidden fields in one of two ways. In real mode the base is derived from the selector and the load completes on the next clock edge. In protected mode the unit reads the two 32-bit words of the descriptor entry from a table in memory. It reads each word once over a request/valid handshake and then latches the decoded fields. A separate debug port can write the selector or any single hidden field, and can read any of them back. A debug write to the selector leaves the hidden fields alone.

Every address request is compared with the cached limit of its segment. An offset above the limit raises a fault flag together with the linear address.

Top module: `segDescCache`

## Requirements
- R1: After reset, segment 0 (code) holds selector F000, base FFFF0000, limit 0000FFFF and access rights 09B. Segments 1 to 3 hold selector 0000, base 0, limit 0000FFFF and access rights 093. An offset of 0000FFF0 on segment 0 gives linear address FFFFFFF0.
- R2: `linAddr` equals the cached base of `addrSeg` plus `addrOffset`, combinationally, with no dependence on the selector value.
- R3: A load with `loadProt`=0 accepted while idle sets, at the next edge, the selector to `loadSel`, the base to `loadSel` shifted left by 4, and the limit to 0000FFFF. It leaves the access rights unchanged and never raises `busy`.
- R4: A load with `loadProt`=1 accepted while idle raises `busy` from the next cycle until the cycle after the cache is written. The first word is requested at `tableBase + loadSel[15:3]*8` and the second at that address plus 4. Each word is requested exactly once, and `memReq` with a stable `memAddr` is held until `memValid`.
- R5: The first descriptor word is w0 and the second is w1. Decoding gives base = {w1[31:24], w1[7:0], w0[31:16]}, raw limit = {w1[19:16], w0[15:0]} and access rights = {w1[23:20], w1[15:8]}. The selector takes `loadSel`.
- R6: When w1[23] (granularity) is set, the cached limit is the raw limit shifted left by 12 with the low 12 bits set to one. Otherwise it is the raw limit zero-extended.
- R7: Cached fields keep their values until the next program-driven load or debug write of that segment. While idle, `memReq` stays low whatever address requests or `tableBase` changes occur.
- R8: A debug write with field code 0 (selector) changes only the selector; the base, limit, access rights and `linAddr` of that segment are unchanged.
- R9: Debug writes use field codes 0 selector, 1 base, 2 limit and 3 access rights. Each one updates only the addressed field of the addressed segment at the next edge. `dbgRdData` returns the field chosen by `dbgRdSeg` and `dbgRdField`, zero-extended.
- R10: `limitFault` is high exactly when `addrValid` is high and `addrOffset` is greater than the cached limit of `addrSeg`, in the same cycle as `linAddr`.
- R11: A load presented while `busy` is high is ignored. It changes no field of any segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Program-driven selector load strobe |
| loadProt | input | 1 | 1 = protected-mode load, 0 = real-mode load |
| loadSeg | input | 2 | Segment being loaded |
| loadSel | input | 16 | Selector value being loaded |
| busy | output | 1 | Protected-mode load in progress |
| tableBase | input | 32 | Descriptor table base address |
| memReq | output | 1 | Descriptor word read request |
| memAddr | output | 32 | Descriptor word address |
| memValid | input | 1 | Read data valid, completes the request |
| memData | input | 32 | Read data |
| addrValid | input | 1 | Address request valid |
| addrSeg | input | 2 | Segment used for the address |
| addrOffset | input | 32 | Offset added to the cached base |
| linAddr | output | 32 | Linear address |
| limitFault | output | 1 | Offset exceeds cached limit |
| dbgWrEn | input | 1 | Debug write strobe |
| dbgSeg | input | 2 | Debug write segment |
| dbgField | input | 2 | Debug write field code |
| dbgWrData | input | 32 | Debug write data (low bits used for narrow fields) |
| dbgRdSeg | input | 2 | Debug read segment |
| dbgRdField | input | 2 | Debug read field code |
| dbgRdData | output | 32 | Debug read data |

## Verification
The assertions assume that `tableBase` stays constant while `busy` is high, and that `memValid` arrives only while `memReq` is high. The address-hold property also assumes that the address inputs alone cannot change a cached field. The bench's memory responder raises `memValid` only after it has seen a request and compared its address, and holds it for a single cycle. `tableBase` is changed only between loads. Debug and load strobes last one cycle each. The single intruding load is issued during a table read to exercise the ignore rule.

// File: rtl/segPkg.sv
package segPkg;
  localparam int SEL_W  = 16;
  localparam int ADDR_W = 32;
  localparam int AR_W   = 12;

  typedef enum logic [1:0] {
    FLD_SEL   = 2'd0,
    FLD_BASE  = 2'd1,
    FLD_LIMIT = 2'd2,
    FLD_AR    = 2'd3
  } dbgField_e;

  typedef struct packed {
    logic captureReq;  // latch pending segment and selector
    logic hiPhase;     // second descriptor word is being read
    logic latchLo;     // store first word
    logic latchHi;     // store second word
    logic commitProt;  // write decoded descriptor into cache
    logic commitReal;  // write real-mode values into cache
  } ctrlStrobes_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadValid,
  input  logic         loadProt,
  input  logic         memValid,
  output logic         busy,
  output logic         memReq,
  output ctrlStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD_LO, ST_RD_HI, ST_COMMIT} state_e;
  state_e state, stateNext;

  logic accept;
  assign accept = loadValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept && loadProt) stateNext = ST_RD_LO;
      ST_RD_LO:  if (memValid) stateNext = ST_RD_HI;
      ST_RD_HI:  if (memValid) stateNext = ST_COMMIT;
      ST_COMMIT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_RD_LO) || (state == ST_RD_HI);

  always_comb begin
    strobes            = '0;
    strobes.captureReq = accept && loadProt;
    strobes.commitReal = accept && !loadProt;
    strobes.hiPhase    = (state == ST_RD_HI);
    strobes.latchLo    = (state == ST_RD_LO) && memValid;
    strobes.latchHi    = (state == ST_RD_HI) && memValid;
    strobes.commitProt = (state == ST_COMMIT);
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [SEG_W-1:0]   loadSeg,
  input  logic [SEL_W-1:0]   loadSel,
  input  logic [ADDR_W-1:0]  tableBase,
  input  logic [ADDR_W-1:0]  memData,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               addrValid,
  input  logic [SEG_W-1:0]   addrSeg,
  input  logic [ADDR_W-1:0]  addrOffset,
  output logic [ADDR_W-1:0]  linAddr,
  output logic               limitFault,
  input  logic               dbgWrEn,
  input  logic [SEG_W-1:0]   dbgSeg,
  input  logic [1:0]         dbgField,
  input  logic [ADDR_W-1:0]  dbgWrData,
  input  logic [SEG_W-1:0]   dbgRdSeg,
  input  logic [1:0]         dbgRdField,
  output logic [ADDR_W-1:0]  dbgRdData
);
  localparam logic [SEL_W-1:0]  CODE_SEL_RST  = 16'hF000;
  localparam logic [ADDR_W-1:0] CODE_BASE_RST = 32'hFFFF_0000;
  localparam logic [ADDR_W-1:0] REAL_LIMIT    = 32'h0000_FFFF;
  localparam logic [AR_W-1:0]   CODE_AR_RST   = 12'h09B;
  localparam logic [AR_W-1:0]   DATA_AR_RST   = 12'h093;

  logic [SEL_W-1:0]  selReg   [NUM_SEG];
  logic [ADDR_W-1:0] baseReg  [NUM_SEG];
  logic [ADDR_W-1:0] limitReg [NUM_SEG];
  logic [AR_W-1:0]   arReg    [NUM_SEG];

  // pending protected-mode load
  logic [SEG_W-1:0]  pendSeg;
  logic [SEL_W-1:0]  pendSel;
  logic [ADDR_W-1:0] loWord;
  logic [ADDR_W-1:0] hiWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSeg <= '0;
      pendSel <= '0;
      loWord  <= '0;
      hiWord  <= '0;
    end else begin
      if (strobes.captureReq) begin
        pendSeg <= loadSeg;
        pendSel <= loadSel;
      end
      if (strobes.latchLo) loWord <= memData;
      if (strobes.latchHi) hiWord <= memData;
    end
  end

  // descriptor entry address: index field times eight, plus four for word two
  logic [ADDR_W-1:0] entryAddr;
  assign entryAddr = tableBase + ADDR_W'({pendSel[SEL_W-1:3], 3'b000});
  assign memAddr   = strobes.hiPhase ? entryAddr + ADDR_W'(4) : entryAddr;

  // descriptor decode
  logic [ADDR_W-1:0] decBase;
  logic [19:0]       rawLimit;
  logic [ADDR_W-1:0] decLimit;
  logic [AR_W-1:0]   decAr;
  assign decBase  = {hiWord[31:24], hiWord[7:0], loWord[31:16]};
  assign rawLimit = {hiWord[19:16], loWord[15:0]};
  assign decLimit = hiWord[23] ? {rawLimit, 12'hFFF} : {12'h000, rawLimit};
  assign decAr    = {hiWord[23:20], hiWord[15:8]};

  // real-mode base from selector
  logic [ADDR_W-1:0] realBase;
  assign realBase = ADDR_W'({loadSel, 4'h0});

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    localparam logic [SEG_W-1:0] IDX = SEG_W'(g);
    logic protHit, realHit, dbgHit;
    assign protHit = strobes.commitProt && (pendSeg == IDX);
    assign realHit = strobes.commitReal && (loadSeg == IDX);
    assign dbgHit  = dbgWrEn && (dbgSeg == IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        selReg[g]   <= (g == 0) ? CODE_SEL_RST  : '0;
        baseReg[g]  <= (g == 0) ? CODE_BASE_RST : '0;
        limitReg[g] <= REAL_LIMIT;
        arReg[g]    <= (g == 0) ? CODE_AR_RST   : DATA_AR_RST;
      end else if (protHit) begin
        selReg[g]   <= pendSel;
        baseReg[g]  <= decBase;
        limitReg[g] <= decLimit;
        arReg[g]    <= decAr;
      end else if (realHit) begin
        selReg[g]   <= loadSel;
        baseReg[g]  <= realBase;
        limitReg[g] <= REAL_LIMIT;
      end else if (dbgHit) begin
        unique case (dbgField)
          FLD_SEL:   selReg[g]   <= dbgWrData[SEL_W-1:0];
          FLD_BASE:  baseReg[g]  <= dbgWrData;
          FLD_LIMIT: limitReg[g] <= dbgWrData;
          FLD_AR:    arReg[g]    <= dbgWrData[AR_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // address formation uses only the hidden base
  assign linAddr    = baseReg[addrSeg] + addrOffset;
  assign limitFault = addrValid && (addrOffset > limitReg[addrSeg]);

  always_comb begin
    unique case (dbgRdField)
      FLD_SEL:   dbgRdData = ADDR_W'(selReg[dbgRdSeg]);
      FLD_BASE:  dbgRdData = baseReg[dbgRdSeg];
      FLD_LIMIT: dbgRdData = limitReg[dbgRdSeg];
      FLD_AR:    dbgRdData = ADDR_W'(arReg[dbgRdSeg]);
      default:   dbgRdData = '0;
    endcase
  end
endmodule

// File: rtl/segDescCache.sv
module segDescCache
  import segPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadValid,
  input  logic        loadProt,
  input  logic [1:0]  loadSeg,
  input  logic [15:0] loadSel,
  output logic        busy,
  input  logic [31:0] tableBase,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memValid,
  input  logic [31:0] memData,
  input  logic        addrValid,
  input  logic [1:0]  addrSeg,
  input  logic [31:0] addrOffset,
  output logic [31:0] linAddr,
  output logic        limitFault,
  input  logic        dbgWrEn,
  input  logic [1:0]  dbgSeg,
  input  logic [1:0]  dbgField,
  input  logic [31:0] dbgWrData,
  input  logic [1:0]  dbgRdSeg,
  input  logic [1:0]  dbgRdField,
  output logic [31:0] dbgRdData
);
  ctrlStrobes_t strobes;

  segCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .loadProt  (loadProt),
    .memValid  (memValid),
    .busy      (busy),
    .memReq    (memReq),
    .strobes   (strobes)
  );

  segDatapath #(.NUM_SEG(4)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .loadSeg    (loadSeg),
    .loadSel    (loadSel),
    .tableBase  (tableBase),
    .memData    (memData),
    .memAddr    (memAddr),
    .addrValid  (addrValid),
    .addrSeg    (addrSeg),
    .addrOffset (addrOffset),
    .linAddr    (linAddr),
    .limitFault (limitFault),
    .dbgWrEn    (dbgWrEn),
    .dbgSeg     (dbgSeg),
    .dbgField   (dbgField),
    .dbgWrData  (dbgWrData),
    .dbgRdSeg   (dbgRdSeg),
    .dbgRdField (dbgRdField),
    .dbgRdData  (dbgRdData)
  );
endmodule

// File: rtl/segDescCacheChk.sv
module segDescCacheChk (
  input logic        clk,
  input logic        rstN,
  input logic        loadValid,
  input logic        loadProt,
  input logic        busy,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        memValid,
  input logic        addrValid,
  input logic [1:0]  addrSeg,
  input logic [31:0] addrOffset,
  input logic [31:0] linAddr,
  input logic        limitFault,
  input logic        dbgWrEn
);
  logic [2:0] reqCnt;
  always_ff @(posedge clk) begin
    if (!rstN) reqCnt <= '0;
    else if (loadValid && loadProt && !busy) reqCnt <= '0;
    else if (memReq && memValid) reqCnt <= reqCnt + 3'd1;
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R4
  two_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (reqCnt == 3'd2));

  // R3
  real_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !loadProt && !busy) |=> !busy);

  // R7
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!dbgWrEn && !loadValid && !busy) && $stable(addrSeg) && $stable(addrOffset))
      |-> $stable(linAddr));

  // R10
  fault_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    limitFault |-> addrValid);
endmodule

bind segDescCache segDescCacheChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadValid  (loadValid),
  .loadProt   (loadProt),
  .busy       (busy),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memValid   (memValid),
  .addrValid  (addrValid),
  .addrSeg    (addrSeg),
  .addrOffset (addrOffset),
  .linAddr    (linAddr),
  .limitFault (limitFault),
  .dbgWrEn    (dbgWrEn)
);

// File: tb/segDescCache_tb.sv
module segDescCache_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        loadValid, loadProt;
  logic [1:0]  loadSeg;
  logic [15:0] loadSel;
  logic        busy;
  logic [31:0] tableBase;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid;
  logic [31:0] memData;
  logic        addrValid;
  logic [1:0]  addrSeg;
  logic [31:0] addrOffset;
  logic [31:0] linAddr;
  logic        limitFault;
  logic        dbgWrEn;
  logic [1:0]  dbgSeg, dbgField;
  logic [31:0] dbgWrData;
  logic [1:0]  dbgRdSeg, dbgRdField;
  logic [31:0] dbgRdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  segDescCache u_dut (.*);

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readField(input logic [1:0] seg, input logic [1:0] fld, output logic [31:0] val);
    dbgRdSeg = seg; dbgRdField = fld;
    #1 val = dbgRdData;
  endtask

  task automatic expectField(input string req, input logic [1:0] seg, input logic [1:0] fld,
                             input logic [31:0] exp);
    logic [31:0] v;
    readField(seg, fld, v);
    check32(req, v, exp);
  endtask

  task automatic expectAddr(input string req, input logic [1:0] seg, input logic [31:0] off,
                            input logic [31:0] expAddr, input logic expFault);
    @(negedge clk);
    addrValid = 1'b1; addrSeg = seg; addrOffset = off;
    #1;
    check32(req, linAddr, expAddr);
    check32(req, {31'b0, limitFault}, {31'b0, expFault});
    addrValid = 1'b0;
  endtask

  task automatic dbgWrite(input logic [1:0] seg, input logic [1:0] fld, input logic [31:0] data);
    @(negedge clk);
    dbgWrEn = 1'b1; dbgSeg = seg; dbgField = fld; dbgWrData = data;
    @(negedge clk);
    dbgWrEn = 1'b0;
  endtask

  task automatic realLoad(input logic [1:0] seg, input logic [15:0] sel);
    @(negedge clk);
    loadValid = 1'b1; loadProt = 1'b0; loadSeg = seg; loadSel = sel;
    @(negedge clk);
    loadValid = 1'b0;
    check32("R3 busy", {31'b0, busy}, 32'd0);
  endtask

  task automatic protLoad(input logic [1:0] seg, input logic [15:0] sel,
                          input logic [31:0] w0, input logic [31:0] w1, input bit intrude);
    int hs = 0;
    logic [31:0] entry;
    entry = tableBase + {16'b0, sel[15:3], 3'b000};
    @(negedge clk);
    loadValid = 1'b1; loadProt = 1'b1; loadSeg = seg; loadSel = sel;
    @(negedge clk);
    loadValid = 1'b0;
    check32("R4 busy raised", {31'b0, busy}, 32'd1);
    if (intrude) begin
      // R11: real-mode load on segment 1 while busy
      loadValid = 1'b1; loadProt = 1'b0; loadSeg = 2'd1; loadSel = 16'h1000;
      @(negedge clk);
      loadValid = 1'b0;
    end
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 10 && !memReq; k++) @(negedge clk);
      check32("R4 request", {31'b0, memReq}, 32'd1);
      check32("R4 word address", memAddr, entry + 32'(w * 4));
      @(negedge clk);
      check32("R4 request held", {31'b0, memReq}, 32'd1);
      memValid = 1'b1; memData = (w == 0) ? w0 : w1;
      @(negedge clk);
      memValid = 1'b0; memData = '0;
      hs++;
    end
    for (int k = 0; k < 5 && busy; k++) @(negedge clk);
    check32("R4 busy cleared", {31'b0, busy}, 32'd0);
    check32("R4 handshakes", 32'(hs), 32'd2);
  endtask

  task automatic testReset();
    expectField("R1 code sel", 2'd0, 2'd0, 32'h0000_F000);
    expectField("R1 code base", 2'd0, 2'd1, 32'hFFFF_0000);
    expectField("R1 code limit", 2'd0, 2'd2, 32'h0000_FFFF);
    expectField("R1 code ar", 2'd0, 2'd3, 32'h0000_009B);
    expectField("R1 data sel", 2'd3, 2'd0, 32'h0);
    expectField("R1 data ar", 2'd1, 2'd3, 32'h0000_0093);
    check32("R1 busy", {31'b0, busy}, 32'd0);
    expectAddr("R1 first fetch", 2'd0, 32'h0000_FFF0, 32'hFFFF_FFF0, 1'b0);
  endtask

  task automatic testReal();
    realLoad(2'd1, 16'hF800);
    expectField("R3 sel", 2'd1, 2'd0, 32'h0000_F800);
    expectField("R3 base", 2'd1, 2'd1, 32'h000F_8000);
    expectField("R3 limit", 2'd1, 2'd2, 32'h0000_FFFF);
    expectField("R3 ar kept", 2'd1, 2'd3, 32'h0000_0093);
    expectAddr("R2 real addr", 2'd1, 32'h0000_0010, 32'h000F_8010, 1'b0);
    expectAddr("R10 real fault", 2'd1, 32'h0001_0000, 32'h0010_8000, 1'b1);
  endtask

  task automatic testProt();
    tableBase = 32'h0001_0000;
    protLoad(2'd2, 16'h0010, 32'h5678_ABCD, 32'h1240_9A34, 1'b0);
    expectField("R5 sel", 2'd2, 2'd0, 32'h0000_0010);
    expectField("R5 base", 2'd2, 2'd1, 32'h1234_5678);
    expectField("R5 limit", 2'd2, 2'd2, 32'h0000_ABCD);
    expectField("R5 ar", 2'd2, 2'd3, 32'h0000_049A);
    expectAddr("R2 prot addr", 2'd2, 32'h0000_0100, 32'h1234_5778, 1'b0);
    expectAddr("R10 at limit", 2'd2, 32'h0000_ABCD, 32'h1235_0245, 1'b0);
    expectAddr("R10 over limit", 2'd2, 32'h0000_ABCE, 32'h1235_0246, 1'b1);
  endtask

  task automatic testGran();
    protLoad(2'd3, 16'h0018, 32'h0000_0002, 32'h00C0_9200, 1'b0);
    expectField("R6 limit", 2'd3, 2'd2, 32'h0000_2FFF);
    expectField("R6 ar", 2'd3, 2'd3, 32'h0000_0C92);
    expectAddr("R6 at limit", 2'd3, 32'h0000_2FFF, 32'h0000_2FFF, 1'b0);
    expectAddr("R6 over limit", 2'd3, 32'h0000_3000, 32'h0000_3000, 1'b1);
  endtask

  task automatic testPersist();
    tableBase = 32'h0ABC_0000;
    for (int i = 0; i < 8; i++) begin
      expectAddr("R7 hold addr", 2'd2, 32'(i * 16), 32'h1234_5678 + 32'(i * 16), 1'b0);
      check32("R7 no request", {31'b0, memReq}, 32'd0);
    end
    expectField("R7 base kept", 2'd2, 2'd1, 32'h1234_5678);
    tableBase = 32'h0001_0000;
  endtask

  task automatic testDbgSel();
    dbgWrite(2'd2, 2'd0, 32'h0000_BEEF);
    expectField("R8 sel written", 2'd2, 2'd0, 32'h0000_BEEF);
    expectField("R8 base kept", 2'd2, 2'd1, 32'h1234_5678);
    expectField("R8 limit kept", 2'd2, 2'd2, 32'h0000_ABCD);
    expectField("R8 ar kept", 2'd2, 2'd3, 32'h0000_049A);
    expectAddr("R8 addr kept", 2'd2, 32'h0000_0100, 32'h1234_5778, 1'b0);
  endtask

  task automatic testDbgFields();
    dbgWrite(2'd1, 2'd1, 32'hA000_0000);
    expectAddr("R9 base write", 2'd1, 32'h0000_0004, 32'hA000_0004, 1'b0);
    expectField("R9 sel untouched", 2'd1, 2'd0, 32'h0000_F800);
    dbgWrite(2'd1, 2'd2, 32'h0000_0020);
    expectAddr("R9 limit write", 2'd1, 32'h0000_0021, 32'hA000_0021, 1'b1);
    dbgWrite(2'd1, 2'd3, 32'h0000_05A5);
    expectField("R9 ar write", 2'd1, 2'd3, 32'h0000_05A5);
    expectField("R9 base untouched", 2'd1, 2'd1, 32'hA000_0000);
    expectField("R9 other seg", 2'd0, 2'd1, 32'hFFFF_0000);
  endtask

  task automatic testBusyIgnore();
    protLoad(2'd0, 16'h0008, 32'h0000_0FFF, 32'h0000_9B00, 1'b1);
    expectField("R11 seg1 base", 2'd1, 2'd1, 32'hA000_0000);
    expectField("R11 seg1 sel", 2'd1, 2'd0, 32'h0000_F800);
    expectField("R11 seg1 limit", 2'd1, 2'd2, 32'h0000_0020);
    expectField("R5 code base", 2'd0, 2'd1, 32'h0000_0000);
    expectField("R5 code limit", 2'd0, 2'd2, 32'h0000_0FFF);
  endtask

  initial begin
    rstN = 1'b0;
    loadValid = 0; loadProt = 0; loadSeg = 0; loadSel = 0;
    tableBase = 0; memValid = 0; memData = 0;
    addrValid = 0; addrSeg = 0; addrOffset = 0;
    dbgWrEn = 0; dbgSeg = 0; dbgField = 0; dbgWrData = 0;
    dbgRdSeg = 0; dbgRdField = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReal();
    testProt();
    testGran();
    testPersist();
    testDbgSel();
    testDbgFields();
    testBusyIgnore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule